// File: doc/BRIEF.md
# Stand-alone Conversion Start Controller

This block decides when a temperature converter is told to start when no processor is attached. A single shared clock/convert pin carries the request, and the length of its low pulse selects the kind of request. A low pulse shorter than a programmable number of millisecond ticks asks for one conversion. A low level held at least that long asks for conversions back to back until the pin returns high. Pin requests work only while the processor-mode bit is clear and the serial-port reset line is low. They take effect even when the one-shot configuration bit is set.

When the block is enabled, the pin rests high, the one-shot bit is clear and no pin request is being served, the block starts conversions one after another on its own. Every start is a one-clock pulse to the converter. The converter reports the end of each conversion with a one-clock done pulse. The block never issues a new start while a conversion it started is still outstanding.

The pin passes through a two-flop synchroniser before any edge is detected. The low time is measured by counting an external millisecond tick.

Top module: `conv_start_ctrl`

## Requirements
- R1: `conv_start_o` is low while `rst` is high and in the cycle after reset. Every start is exactly one clock wide.
- R2: While `cpu_mode_i` is 1, no start is issued. This covers pin-driven starts and free-running starts. A start never follows a cycle in which `cpu_mode_i` was 1.
- R3: While `ser_rst_i` is 1, no start is issued. A start never follows a cycle in which `ser_rst_i` was 1.
- R4: A low pulse on `cvt_pin_i` that spans fewer than `LIMIT_TICKS` ticks of `ms_tick_i` gives exactly one start. The block is then quiet if `one_shot_i` is 1.
- R5: A low level on `cvt_pin_i` held for at least `LIMIT_TICKS` ticks gives repeated starts while it stays low, so at least two starts for a long enough hold.
- R6: When the pin returns high after continuous operation, the conversion in progress is allowed to finish. No further start is issued once the synchronised high level has been seen.
- R7: Pin-driven starts of R4 and R5 occur with `one_shot_i` equal to 1.
- R8: With `cpu_mode_i`=0, `ser_rst_i`=0, `one_shot_i`=0 and the pin idle high, starts repeat without any pin activity.
- R9: No start is issued from the cycle of a start until the cycle after the matching `conv_done_i` pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cvt_pin_i | input | 1 | Asynchronous shared clock/convert pin, idle high |
| ser_rst_i | input | 1 | Serial-port reset line; the pin is examined only when this is low |
| cpu_mode_i | input | 1 | Processor-mode bit; 1 disables stand-alone operation |
| one_shot_i | input | 1 | One-shot configuration bit; 0 allows free-running starts |
| ms_tick_i | input | 1 | One-clock pulse each millisecond |
| conv_done_i | input | 1 | One-clock pulse from the converter when a conversion completes |
| conv_start_o | output | 1 | One-clock conversion start request |

## Verification
The bench keeps the default `LIMIT_TICKS` of 10. It generates `ms_tick_i` every 8 clocks, so the threshold between a single and a continuous request is only 80 clocks away. This makes both sides of it, and random pulse lengths around it, cheap to reach. The bench also models the converter with a done pulse a few clocks after each start. Several continuous conversions therefore fit inside one long pulse, and overlap between starts and outstanding conversions can be observed.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_TIMING_LOW = 3'd1,
        ST_SINGLE     = 3'd2,
        ST_CONTINUOUS = 3'd3,
        ST_FINISH     = 3'd4
    } scc_state_e;

    // Synchronised view of the convert pin
    typedef struct packed {
        logic level;
        logic fell;
    } pin_view_t;

    localparam int unsigned SCC_SYNC_STAGES = 2;
    localparam int unsigned SCC_LIMIT_TICKS = 10;

    function automatic int unsigned scc_cnt_w(input int unsigned lim);
        return (lim < 1) ? 1 : $clog2(lim + 1);
    endfunction

endpackage

// File: rtl/scc_pin_sync.sv
module scc_pin_sync
    import scc_pkg::*;
#(
    parameter int unsigned STAGES = SCC_SYNC_STAGES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_async_i,
    output pin_view_t view_o
);
    localparam int unsigned NST = (STAGES < 2) ? 2 : STAGES;

    logic [NST-1:0] chain_q;
    logic           prev_q;

    generate
        for (genvar i = 0; i < NST; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    chain_q[i] <= 1'b1;
                end else if (i == 0) begin
                    chain_q[i] <= pin_async_i;
                end else begin
                    chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[NST-1];
    end

    always_comb begin
        view_o.level = chain_q[NST-1];
        view_o.fell  = prev_q & ~chain_q[NST-1];
    end

endmodule

// File: rtl/scc_low_timer.sv
module scc_low_timer
    import scc_pkg::*;
#(
    parameter int unsigned LIMIT = SCC_LIMIT_TICKS
) (
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic tick_i,
    output logic long_o
);
    localparam int unsigned CW = scc_cnt_w(LIMIT);
    localparam logic [CW-1:0] LIM = CW'(LIMIT);

    logic [CW-1:0] cnt_q;

    // Counts ticks while timing, saturating at the limit
    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            cnt_q <= '0;
        end else if (tick_i && (cnt_q != LIM)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign long_o = (cnt_q == LIM);

endmodule

// File: rtl/scc_fsm.sv
module scc_fsm
    import scc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      enable_i,
    input  logic      one_shot_i,
    input  pin_view_t view_i,
    input  logic      long_i,
    input  logic      done_i,
    output logic      timing_o,
    output logic      start_o
);
    scc_state_e st_q, st_d;
    logic       req;
    logic       inflight_q;
    logic       fired_q;

    always_comb begin
        st_d = st_q;
        req  = 1'b0;
        if (!enable_i) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (view_i.fell) begin
                        st_d = ST_TIMING_LOW;
                    end else if (view_i.level && !one_shot_i && !inflight_q) begin
                        req = 1'b1;
                    end
                end
                ST_TIMING_LOW: begin
                    if (view_i.level)  st_d = ST_SINGLE;
                    else if (long_i)   st_d = ST_CONTINUOUS;
                end
                ST_SINGLE: begin
                    if (!inflight_q) begin
                        req  = 1'b1;
                        st_d = ST_FINISH;
                    end
                end
                ST_CONTINUOUS: begin
                    if (view_i.level) begin
                        st_d = fired_q ? ST_FINISH : ST_SINGLE;
                    end else if (!inflight_q) begin
                        req = 1'b1;
                    end
                end
                ST_FINISH: begin
                    if (!inflight_q) st_d = ST_IDLE;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= ST_IDLE;
            inflight_q <= 1'b0;
            fired_q    <= 1'b0;
            start_o    <= 1'b0;
        end else begin
            st_q    <= st_d;
            start_o <= req;
            if (req)         inflight_q <= 1'b1;
            else if (done_i) inflight_q <= 1'b0;
            fired_q <= (st_q == ST_CONTINUOUS) ? (fired_q | req) : 1'b0;
        end
    end

    assign timing_o = (st_q == ST_TIMING_LOW);

endmodule

// File: rtl/conv_start_ctrl.sv
module conv_start_ctrl
    import scc_pkg::*;
#(
    parameter int unsigned LIMIT_TICKS = SCC_LIMIT_TICKS,
    parameter int unsigned SYNC_STAGES = SCC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic cvt_pin_i,
    input  logic ser_rst_i,
    input  logic cpu_mode_i,
    input  logic one_shot_i,
    input  logic ms_tick_i,
    input  logic conv_done_i,
    output logic conv_start_o
);
    pin_view_t view;
    logic      timing;
    logic      long_low;
    logic      enable;

    assign enable = ~cpu_mode_i & ~ser_rst_i;

    scc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst         (rst),
        .pin_async_i (cvt_pin_i),
        .view_o      (view)
    );

    scc_low_timer #(.LIMIT(LIMIT_TICKS)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .run_i  (timing),
        .tick_i (ms_tick_i),
        .long_o (long_low)
    );

    scc_fsm u_fsm (
        .clk        (clk),
        .rst        (rst),
        .enable_i   (enable),
        .one_shot_i (one_shot_i),
        .view_i     (view),
        .long_i     (long_low),
        .done_i     (conv_done_i),
        .timing_o   (timing),
        .start_o    (conv_start_o)
    );

endmodule

// File: rtl/scc_checker.sv
module scc_checker (
    input logic clk,
    input logic rst,
    input logic cpu_mode_i,
    input logic ser_rst_i,
    input logic conv_done_i,
    input logic conv_start_o
);
    logic outst_q;

    always_ff @(posedge clk) begin
        if (rst)               outst_q <= 1'b0;
        else if (conv_start_o) outst_q <= 1'b1;
        else if (conv_done_i)  outst_q <= 1'b0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !conv_start_o);                                  // R1

    AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |=> !conv_start_o);                                // R1

    AST_CPU_BLOCK: assert property (@(posedge clk) disable iff (rst)
        $past(cpu_mode_i) |-> !conv_start_o);                           // R2

    AST_SRST_BLOCK: assert property (@(posedge clk) disable iff (rst)
        $past(ser_rst_i) |-> !conv_start_o);                            // R3

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        conv_start_o |-> !outst_q);                                     // R9

endmodule

bind conv_start_ctrl scc_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .cpu_mode_i   (cpu_mode_i),
    .ser_rst_i    (ser_rst_i),
    .conv_done_i  (conv_done_i),
    .conv_start_o (conv_start_o)
);

// File: tb/conv_start_ctrl_tb.sv
module conv_start_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;
    localparam int LIMIT      = 10;
    localparam int CONV_LAT   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cvt_pin = 1'b1;
    logic ser_rst = 1'b0;
    logic cpu_mode = 1'b0;
    logic one_shot = 1'b1;
    logic ms_tick = 1'b0;
    logic conv_done = 1'b0;
    logic conv_start;

    int total = 0;
    int bad = 0;
    int starts = 0;
    int busy_cnt = 0;
    int div_cnt = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    conv_start_ctrl #(.LIMIT_TICKS(LIMIT)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .cvt_pin_i    (cvt_pin),
        .ser_rst_i    (ser_rst),
        .cpu_mode_i   (cpu_mode),
        .one_shot_i   (one_shot),
        .ms_tick_i    (ms_tick),
        .conv_done_i  (conv_done),
        .conv_start_o (conv_start)
    );

    // Millisecond tick and converter model
    always @(posedge clk) begin
        div_cnt <= (div_cnt == TICK_DIV-1) ? 0 : div_cnt + 1;
        ms_tick <= (div_cnt == TICK_DIV-1);
        if (conv_start)        busy_cnt <= CONV_LAT;
        else if (busy_cnt > 0) busy_cnt <= busy_cnt - 1;
        conv_done <= (busy_cnt == 1);
    end

    // Start monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst && conv_start) begin
            starts <= starts + 1;
            total  <= total + 1;
            if (busy_cnt != 0 || conv_done) begin
                bad <= bad + 1;
                $display("FAIL R9: start while busy, act busy=%0d exp=0", busy_cnt);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp_v);
        end
    endtask

    // Lowest start count expected for a pin held low for the given tick count
    function automatic int exp_min(input int ticks);
        return (ticks < LIMIT) ? 1 : 2;
    endfunction

    function automatic bit is_single(input int ticks);
        return ticks < LIMIT;
    endfunction

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Low pulse measured in ticks; returns starts from fall to settle
    task automatic pulse(input int ticks, output int cnt, output int after);
        int s0;
        int s1;
        s0 = starts;
        cvt_pin = 1'b0;
        wait_cyc(ticks * TICK_DIV);
        cvt_pin = 1'b1;
        wait_cyc(6);
        s1 = starts;
        wait_cyc(60);
        cnt = starts - s0;
        after = starts - s1;
    endtask

    initial begin
        int c;
        int a;
        int s0;
        void'($urandom(32'd1729));
        wait_cyc(1);
        chk(conv_start == 1'b0, "R1 start low in reset", int'(conv_start), 0);
        wait_cyc(4);
        rst = 1'b0;
        wait_cyc(1);
        chk(conv_start == 1'b0, "R1 start low after reset", int'(conv_start), 0);

        // One-shot set, pin idle: quiet
        s0 = starts;
        wait_cyc(80);
        chk(starts == s0, "R4 quiet with one-shot and idle pin", starts - s0, 0);

        // Free-running
        one_shot = 1'b0;
        s0 = starts;
        wait_cyc(200);
        chk(starts - s0 >= 10, "R8 free-running starts", starts - s0, 10);

        // CPU mode blocks everything
        cpu_mode = 1'b1;
        wait_cyc(12);
        s0 = starts;
        wait_cyc(50);
        pulse(4, c, a);
        pulse(20, c, a);
        chk(starts == s0, "R2 cpu mode blocks starts", starts - s0, 0);
        cpu_mode = 1'b0;

        // Serial reset blocks everything
        ser_rst = 1'b1;
        wait_cyc(12);
        s0 = starts;
        pulse(4, c, a);
        pulse(20, c, a);
        chk(starts == s0, "R3 serial reset blocks starts", starts - s0, 0);
        ser_rst = 1'b0;
        one_shot = 1'b1;
        wait_cyc(30);

        // Directed short pulse with one-shot set
        pulse(4, c, a);
        chk(c == 1, "R4 R7 short pulse gives one start", c, 1);
        // Boundary just below threshold
        pulse(8, c, a);
        chk(c == 1, "R4 pulse below limit gives one start", c, 1);
        // Long pulse
        pulse(14, c, a);
        chk(c >= 2, "R5 R7 long pulse repeats", c, 2);
        chk(a == 0, "R6 no start after pin returns high", a, 0);
        pulse(30, c, a);
        chk(c >= 5, "R5 long hold gives many starts", c, 5);
        chk(a == 0, "R6 stop after long hold", a, 0);

        // Random pulse lengths away from the threshold
        for (int i = 0; i < 20; i++) begin
            int t;
            if ($urandom_range(1, 0) == 1) t = $urandom_range(8, 1);
            else                           t = $urandom_range(30, 14);
            pulse(t, c, a);
            if (is_single(t)) chk(c == exp_min(t), "R4 random short pulse", c, exp_min(t));
            else              chk(c >= exp_min(t), "R5 random long pulse", c, exp_min(t));
            chk(a == 0, "R6 random quiet after release", a, 0);
        end

        wait_cyc(5);
        if (!finished) begin
            finished = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            total++;
            bad++;
            $display("FAIL watchdog: act=timeout exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule